// File: doc/BRIEF.md
# Canonical Signed-Digit Recoder

This block turns an N-bit multiplier operand into its canonical signed-digit form. In this form every digit is -1, 0 or +1, and no two neighbouring digits are both nonzero. This form has the fewest nonzero digits of any signed-digit representation of the value. A multiplier control path can read the digit string and issue one add or one subtract for each nonzero digit. It can also read the nonzero count to learn in advance how many such operations the product will cost.

The recoder is sequential. A load strobe captures the operand and a mode flag that marks the operand as two's complement or unsigned. After that, the block walks the operand one bit position per clock, starting at the least significant end. A carry flag remembers whether the walk is currently inside a run of ones. At each position the block examines the current bit, the bit one place higher and the carry, and from these it writes one digit. The operand is widened by one position above its top bit. In signed mode this position holds a copy of the sign. In unsigned mode it holds a zero. The result therefore has N+1 digits. When the last digit is written, a valid flag rises and stays high until the next load.

Top module: `csd_recoder`

## Requirements
- R1: After reset, valid_o is 0, every digit is zero and nz_count_o is 0.
- R2: The clock edge that samples load_i high captures mult_i and signed_i and restarts the walk. After that edge valid_o is 0, all digits are zero and nz_count_o is 0. A load during a walk or while the result is valid abandons the earlier operand.
- R3: valid_o rises exactly N+1 clock edges after the load edge. It then stays high, with digits_o and nz_count_o unchanged, until the next load.
- R4: Digit i occupies digits_o[2i+1:2i]. Bit 2i+1 is the nonzero flag and bit 2i is the negative flag. Code 00 means 0, 10 means +1 and 11 means -1. Code 01 never appears.
- R5: In signed mode (signed_i=1), the sum over i of digit_i·2^i equals the two's complement value of the operand.
- R6: In unsigned mode (signed_i=0), the sum over i of digit_i·2^i equals the unsigned value of the operand.
- R7: When valid_o is high, no two adjacent digits are both nonzero.
- R8: nz_count_o always equals the number of nonzero digits currently on digits_o.
- R9: Unsigned or signed operand 01101110 recodes to +1 at digit 7, -1 at digit 4, -1 at digit 1, and zero elsewhere.
- R10: For N=8, the corner operands recode as follows. Signed all-ones gives only -1 at digit 0. Unsigned all-ones gives -1 at digit 0 and +1 at digit 8. Signed 10000000 gives only -1 at digit 7.
- R11: Digits are written in order from digit 0 upward, one per clock. After the k-th edge following the load edge, digits 0 to k-1 hold their final values and the digits above them are still zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture the operand and start a new walk |
| signed_i | input | 1 | 1: operand is two's complement; 0: operand is unsigned |
| mult_i | input | N | Multiplier operand |
| digits_o | output | 2*(N+1) | Signed digits, two bits each, digit 0 in the lowest pair |
| nz_count_o | output | $clog2(N+2) | Number of nonzero digits written so far |
| valid_o | output | 1 | High once all N+1 digits are final |

## Verification
The hardest behaviour to reach is a new load that arrives part-way through a walk. The carry, the position counter and the partially filled digit store must all restart together. Otherwise stale digits or a stale carry would leak into the new result. The stimulus reaches this case by loading an operand and waiting a few clocks. It then loads a different operand in the opposite mode, and it also issues a load on the same clock that valid rises. Because the bench's reference model is compared on every clock, a leftover digit shows up as soon as it appears. Every operand of the default width is also swept in both modes. This covers runs of ones that reach the top position, the carry that spills into the extra digit, and the case where the sign copy absorbs that carry.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;

  // two-bit signed digit: {nonzero, negative}
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b10,
    DIG_NEG  = 2'b11
  } csd_digit_e;

  // digit produced at one position from the current bit, the bit above it
  // and the run-of-ones carry; an odd local sum becomes a nonzero digit whose
  // sign is chosen by the next bit so that the following position sees zero
  function automatic csd_digit_e csd_digit_of(input logic cur, input logic nxt,
                                              input logic cin);
    if (cur ^ cin) return nxt ? DIG_NEG : DIG_POS;
    return DIG_ZERO;
  endfunction

  // carry leaving one position
  function automatic logic csd_carry_of(input logic cur, input logic nxt,
                                        input logic cin);
    if (cur ^ cin) return nxt;
    return cur & cin;
  endfunction

endpackage

// File: rtl/csd_bit_select.sv
`timescale 1ns/1ps
module csd_bit_select #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     operand,
  input  logic             signed_mode,
  input  logic [IDX_W-1:0] pos,
  output logic             cur_bit,
  output logic             nxt_bit
);

  logic       top_fill;
  logic [N+1:0] ext;

  assign top_fill = signed_mode & operand[N-1];
  assign ext      = {top_fill, top_fill, operand};

  always_comb begin
    cur_bit = 1'b0;
    nxt_bit = 1'b0;
    for (int k = 0; k <= N; k++) begin
      if (pos == IDX_W'(k)) begin
        cur_bit = ext[k];
        nxt_bit = ext[k+1];
      end
    end
  end

endmodule

// File: rtl/csd_step_logic.sv
`timescale 1ns/1ps
module csd_step_logic
  import csd_pkg::*;
(
  input  logic       cur_bit,
  input  logic       nxt_bit,
  input  logic       carry_in,
  output logic [1:0] digit,
  output logic       carry_out
);

  csd_digit_e dig_e;

  assign dig_e     = csd_digit_of(cur_bit, nxt_bit, carry_in);
  assign digit     = dig_e;
  assign carry_out = csd_carry_of(cur_bit, nxt_bit, carry_in);

endmodule

// File: rtl/csd_digit_store.sv
`timescale 1ns/1ps
module csd_digit_store #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N + 1),
  localparam int CNT_W = $clog2(N + 2),
  localparam int NDIG  = N + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_digit,
  output logic [2*NDIG-1:0] digits,
  output logic [CNT_W-1:0]  nz_count
);

  logic [NDIG-1:0] slot_we;
  logic [NDIG-1:0] nz_vec;
  logic [NDIG-1:0] neg_vec;

  for (genvar k = 0; k < NDIG; k++) begin : g_slot
    logic [1:0] dig_q;
    assign slot_we[k] = wr_en && (wr_idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dig_q <= 2'b00;
      else if (clear)      dig_q <= 2'b00;
      else if (slot_we[k]) dig_q <= wr_digit;
    end
    assign digits[2*k +: 2] = dig_q;
    assign nz_vec[k]        = dig_q[1];
    assign neg_vec[k]       = dig_q[0];

    // R4
    enc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(neg_vec[k] && !nz_vec[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   nz_count <= '0;
    else if (clear)               nz_count <= '0;
    else if (wr_en && wr_digit[1]) nz_count <= nz_count + CNT_W'(1);
  end

  // R11
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(nz_count) == $countones(nz_vec));

endmodule

// File: rtl/csd_recoder.sv
`timescale 1ns/1ps
module csd_recoder #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N + 1),
  localparam int CNT_W = $clog2(N + 2),
  localparam int NDIG  = N + 1,
  localparam int CHK_W = $clog2(N + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              signed_i,
  input  logic [N-1:0]      mult_i,
  output logic [2*NDIG-1:0] digits_o,
  output logic [CNT_W-1:0]  nz_count_o,
  output logic              valid_o
);

  logic [N-1:0]     op_q;
  logic             sgn_q;
  logic             busy_q;
  logic             carry_q;
  logic [IDX_W-1:0] pos_q;

  logic       cur_bit, nxt_bit;
  logic [1:0] step_digit;
  logic       step_carry;

  // named internal events
  logic step_fire;
  logic last_step;
  logic restart;

  assign restart   = load_i;
  assign step_fire = busy_q && !load_i;
  assign last_step = step_fire && (pos_q == IDX_W'(N));

  csd_bit_select #(.N(N)) u_sel (
    .operand     (op_q),
    .signed_mode (sgn_q),
    .pos         (pos_q),
    .cur_bit     (cur_bit),
    .nxt_bit     (nxt_bit)
  );

  csd_step_logic u_step (
    .cur_bit   (cur_bit),
    .nxt_bit   (nxt_bit),
    .carry_in  (carry_q),
    .digit     (step_digit),
    .carry_out (step_carry)
  );

  csd_digit_store #(.N(N)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (restart),
    .wr_en    (step_fire),
    .wr_idx   (pos_q),
    .wr_digit (step_digit),
    .digits   (digits_o),
    .nz_count (nz_count_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      sgn_q   <= 1'b0;
      busy_q  <= 1'b0;
      carry_q <= 1'b0;
      pos_q   <= '0;
      valid_o <= 1'b0;
    end else if (restart) begin
      op_q    <= mult_i;
      sgn_q   <= signed_i;
      busy_q  <= 1'b1;
      carry_q <= 1'b0;
      pos_q   <= '0;
      valid_o <= 1'b0;
    end else if (step_fire) begin
      carry_q <= step_carry;
      pos_q   <= pos_q + IDX_W'(1);
      if (last_step) begin
        busy_q  <= 1'b0;
        valid_o <= 1'b1;
      end
    end
  end

  // checker state: edges since the last load, saturating
  logic [CHK_W-1:0] since_load;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_load <= '1;
    else if (load_i)                     since_load <= '0;
    else if (since_load != {CHK_W{1'b1}}) since_load <= since_load + CHK_W'(1);
  end

  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!valid_o && nz_count_o == '0 && digits_o == '0));

  // R3
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> (32'(since_load) == N + 1));

  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !load_i) |=> (valid_o && $stable(digits_o) && $stable(nz_count_o)));

  for (genvar k = 0; k < N; k++) begin : g_adj
    // R7
    no_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !(digits_o[2*k+1] && digits_o[2*k+3]));
  end

endmodule

// File: tb/csd_recoder_tb_top.sv
`timescale 1ns/1ps
module csd_recoder_tb_top;

  localparam int N     = 8;
  localparam int NDIG  = N + 1;
  localparam int CNT_W = $clog2(N + 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_i = 1'b0;
  logic              signed_i = 1'b0;
  logic [N-1:0]      mult_i = '0;
  logic [2*NDIG-1:0] digits_o;
  logic [CNT_W-1:0]  nz_count_o;
  logic              valid_o;

  always #2 clk = ~clk;

  csd_recoder #(.N(N)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .signed_i   (signed_i),
    .mult_i     (mult_i),
    .digits_o   (digits_o),
    .nz_count_o (nz_count_o),
    .valid_o    (valid_o)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference model
  int     m_dig[NDIG];
  int     m_count;
  bit     m_valid;
  bit     m_busy;
  int     m_pos;
  longint m_rem;
  longint m_value;
  bit     m_signed;

  function automatic int port_digit(int i);
    logic [1:0] c = digits_o[2*i +: 2];
    case (c)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return -1;
      default: return 99;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint value_of(logic [N-1:0] x, bit sg);
    longint v = longint'(x);
    if (sg && x[N-1]) v -= (longint'(1) << N);
    return v;
  endfunction

  // model update for one rising edge, using the inputs being driven
  task automatic model_edge();
    if (load_i) begin
      m_busy   = 1;
      m_valid  = 0;
      m_pos    = 0;
      m_count  = 0;
      m_signed = signed_i;
      m_value  = value_of(mult_i, signed_i);
      m_rem    = m_value;
      foreach (m_dig[i]) m_dig[i] = 0;
    end else if (m_busy) begin
      int d;
      if (m_rem[0]) d = 2 - int'(m_rem & 3);
      else          d = 0;
      m_dig[m_pos] = d;
      if (d != 0) m_count++;
      m_rem = (m_rem - longint'(d)) >>> 1;
      if (m_pos == N) begin
        m_busy  = 0;
        m_valid = 1;
      end
      m_pos++;
    end
  endtask

  task automatic compare_cycle();
    bit dig_ok = 1;
    int bad = 0;
    for (int i = 0; i < NDIG; i++) begin
      if (port_digit(i) != m_dig[i]) begin
        dig_ok = 0;
        bad = i;
      end
    end
    check(valid_o == m_valid, "R3", "valid", valid_o, m_valid);
    check(int'(nz_count_o) == m_count, "R8", "count", nz_count_o, m_count);
    check(dig_ok, "R11", $sformatf("digit %0d", bad), port_digit(bad), m_dig[bad]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_cycle();
  endtask

  // checks on a finished result, read from the ports
  task automatic check_result();
    longint sum = 0;
    int nz = 0;
    for (int i = 0; i < NDIG; i++) begin
      int d = port_digit(i);
      check(d != 99, "R4", $sformatf("code at digit %0d", i), d, 0);
      sum += longint'(d) <<< i;
      if (d != 0) nz++;
      if (i > 0)
        check(!(d != 0 && port_digit(i-1) != 0), "R7",
              $sformatf("adjacent pair %0d", i), d, 0);
    end
    if (m_signed) check(sum == m_value, "R5", "signed value", sum, m_value);
    else          check(sum == m_value, "R6", "unsigned value", sum, m_value);
    check(int'(nz_count_o) == nz, "R8", "count vs digits", nz_count_o, nz);
  endtask

  task automatic start(logic [N-1:0] x, bit sg);
    load_i   = 1;
    mult_i   = x;
    signed_i = sg;
    tick();
    load_i = 0;
    check(!valid_o && nz_count_o == '0 && digits_o == '0, "R2", "cleared after load",
          longint'(digits_o), 0);
  endtask

  task automatic run_job(logic [N-1:0] x, bit sg);
    start(x, sg);
    repeat (N) tick();
    check(!valid_o, "R3", "valid early", valid_o, 0);
    tick();
    check(valid_o, "R3", "valid at N+1", valid_o, 1);
    check_result();
  endtask

  task automatic expect_digits(string req, int pa, int da, int pb, int db, int pc, int dc);
    for (int i = 0; i < NDIG; i++) begin
      int e = 0;
      if (i == pa) e = da;
      if (i == pb) e = db;
      if (i == pc) e = dc;
      check(port_digit(i) == e, req, $sformatf("digit %0d", i), port_digit(i), e);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    foreach (m_dig[i]) m_dig[i] = 0;
    m_count = 0; m_valid = 0; m_busy = 0; m_pos = 0; m_rem = 0;
    m_value = 0; m_signed = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!valid_o && digits_o == '0 && nz_count_o == '0, "R1", "reset outputs",
          longint'(digits_o), 0);
    rst_n = 1;
    @(negedge clk);
    compare_cycle();

    // R9 worked example in both modes
    run_job(8'b01101110, 1'b0);
    expect_digits("R9", 7, 1, 4, -1, 1, -1);
    run_job(8'b01101110, 1'b1);
    expect_digits("R9", 7, 1, 4, -1, 1, -1);

    // R10 corner operands
    run_job(8'hFF, 1'b1);
    expect_digits("R10", 0, -1, -1, 0, -1, 0);
    run_job(8'hFF, 1'b0);
    expect_digits("R10", 0, -1, 8, 1, -1, 0);
    run_job(8'h80, 1'b1);
    expect_digits("R10", 7, -1, -1, 0, -1, 0);

    // R3 result held while idle
    repeat (5) tick();
    check(valid_o, "R3", "valid held", valid_o, 1);

    // R2 restart in the middle of a walk, other mode
    start(8'b10110101, 1'b1);
    repeat (4) tick();
    run_job(8'b01011011, 1'b0);

    // R2 load on the edge right after valid rises
    start(8'h55, 1'b0);
    repeat (N + 1) tick();
    run_job(8'hAA, 1'b1);

    // exhaustive sweep, both modes
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < (1 << N); v++)
        run_job(N'(v), s[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule